// File: doc/BRIEF.md
# Selective Scan Test Sequencer

This block steps a partial-scan chain through a stream of test patterns. Each pattern arrives as a descriptor over a valid/ready handshake. A descriptor gives a shift count, the serial test bits for those shifts, a concurrent-capture flag, a scanless flag and a final-pattern marker. For each descriptor the sequencer drives five things: the chain's scan-enable line, the clock enable of the scanned flip-flop group, the clock enable of the non-scanned group, the serial scan-in bit and a capture strobe.

The shift count varies from one pattern to the next. The test generator sets it to the larger of two distances: how far the farthest useful response bit sits from scan-out, and how far the farthest useful test bit must travel from scan-in. Between patterns both groups are held, so bits that were not shifted stay where they are and leave the chain during later scan-ins. When the concurrent flag is set, the final shift of a pattern shares its cycle with the capture. A scanless descriptor applies one functional cycle with no shifting at all.

A strobe marks every cycle in which the serial output carries a valid bit, so an external comparator knows when to sample it. After the final pattern the chain is flushed with a full chain length of shifts. The block also keeps a running count of the clock cycles it has applied to the chain.

Top module: `sel_scan_seq`

## Requirements
- R1: After reset `desc_ready` is 1, `done` is 0, `cycle_count` is 0, and `scan_en`, `sff_en`, `nsff_en`, `capture` and `so_valid` are all 0.
- R2: On a shift cycle, `scan_en`, `sff_en` and `so_valid` are 1. Unless the cycle is also a capture, `nsff_en` is 0. The descriptor's `desc_data` bits appear on `scan_in` one per shift, bit 0 first.
- R3: The number of shift cycles for a descriptor is the smaller of `desc_shifts` and the chain length `CHAIN_LEN`.
- R4: Each non-scanless descriptor ends with exactly one capture (`capture`=1, `sff_en`=1, `nsff_en`=1). When the concurrent flag is clear, the capture is a cycle of its own after the shifts, with `scan_en`=0 and `so_valid`=0. A shift count of zero gives only that capture cycle.
- R5: When `desc_concur`=1 and the effective shift count is at least 1, the final shift and the capture fall in one cycle. In that cycle `scan_en`, `sff_en`, `nsff_en`, `capture` and `so_valid` are all 1, so the pattern takes exactly as many cycles as it has shifts. The flag has no effect when the count is zero.
- R6: A descriptor with `desc_scanless`=1 applies exactly one functional cycle (`scan_en`=0, both enables 1) and no shifts, whatever its shift count.
- R7: While waiting for a descriptor (`desc_ready`=1), `scan_en`, `sff_en` and `nsff_en` are all 0, so both groups hold.
- R8: After the capture of a descriptor with `desc_last`=1, the chain gets exactly `CHAIN_LEN` flush shifts with `scan_in`=0. `done` then rises and stays 1, `desc_ready` stays 0, and any descriptor offered later changes no output.
- R9: `cycle_count` rises by exactly one on each cycle in which `sff_en` or `nsff_en` is 1, and it is otherwise unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Sequencer can take a descriptor |
| desc_shifts | input | SHW | Requested shift count |
| desc_data | input | CHAIN_LEN | Serial test bits, bit 0 shifted first |
| desc_concur | input | 1 | Merge the final shift with the capture |
| desc_last | input | 1 | Final pattern; flush the chain afterwards |
| desc_scanless | input | 1 | Functional cycle only, no shifting |
| scan_en | output | 1 | Chain shift mode select |
| sff_en | output | 1 | Clock enable, scanned group |
| nsff_en | output | 1 | Clock enable, non-scanned group |
| scan_in | output | 1 | Serial bit into the chain |
| capture | output | 1 | Functional capture strobe |
| so_valid | output | 1 | Serial output valid for comparison |
| done | output | 1 | Flush complete |
| cycle_count | output | CNT_W | Applied test clock cycles |

## Verification
A wrong remaining-shift count shows at once as one too many or one too few `so_valid` cycles in the pattern it hits. It also moves the capture strobe by the same amount, so it is visible within a single descriptor. A corrupted data register puts a wrong bit on `scan_in` in the very cycle it is shifted. A stuck concurrent or last flag adds or removes a capture, or runs a flush of `CHAIN_LEN` cycles that should not happen, and both of these show before the next handshake. Counter faults build up and are exposed by comparing the final `cycle_count` with the sum worked out from the descriptors.

// File: rtl/sss_pkg.sv
package sss_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_CAP,
        ST_FLUSH,
        ST_DONE
    } sss_state_e;
endpackage

// File: rtl/sss_ctrl.sv
module sss_ctrl
    import sss_pkg::*;
#(
    parameter int CHAIN_LEN = 8,
    parameter int SHW       = $clog2(CHAIN_LEN + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           desc_valid,
    input  logic [SHW-1:0] desc_shifts,
    input  logic           desc_concur,
    input  logic           desc_last,
    input  logic           desc_scanless,
    output logic           desc_ready,
    output logic           accept,
    output logic           advance,
    output logic           scan_en,
    output logic           sff_en,
    output logic           nsff_en,
    output logic           capture,
    output logic           so_valid,
    output logic           data_sel,
    output logic           done
);
    localparam logic [SHW-1:0] LEN_W = SHW'(CHAIN_LEN);
    localparam logic [SHW-1:0] ONE_W = SHW'(1);

    typedef struct packed {
        sss_state_e     state;
        logic [SHW-1:0] rem;
        logic           concur;
        logic           last;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic [SHW-1:0] eff_shifts;
    logic           merged;

    assign eff_shifts = (desc_shifts > LEN_W) ? LEN_W : desc_shifts;
    assign merged     = (ctl_q.state == ST_SHIFT) && (ctl_q.rem == ONE_W) && ctl_q.concur;

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (desc_valid) begin
                    ctl_d.concur = desc_concur;
                    ctl_d.last   = desc_last;
                    ctl_d.rem    = eff_shifts;
                    if (desc_scanless || (eff_shifts == '0)) ctl_d.state = ST_CAP;
                    else                                      ctl_d.state = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                ctl_d.rem = ctl_q.rem - ONE_W;
                if (ctl_q.rem == ONE_W) begin
                    if (!ctl_q.concur) begin
                        ctl_d.state = ST_CAP;
                    end else if (ctl_q.last) begin
                        ctl_d.state = ST_FLUSH;
                        ctl_d.rem   = LEN_W;
                    end else begin
                        ctl_d.state = ST_IDLE;
                    end
                end
            end
            ST_CAP: begin
                if (ctl_q.last) begin
                    ctl_d.state = ST_FLUSH;
                    ctl_d.rem   = LEN_W;
                end else begin
                    ctl_d.state = ST_IDLE;
                end
            end
            ST_FLUSH: begin
                ctl_d.rem = ctl_q.rem - ONE_W;
                if (ctl_q.rem == ONE_W) ctl_d.state = ST_DONE;
            end
            default: ctl_d.state = ST_DONE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, rem: '0, concur: 1'b0, last: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        desc_ready = (ctl_q.state == ST_IDLE);
        accept     = desc_ready && desc_valid;
        advance    = (ctl_q.state == ST_SHIFT);
        data_sel   = (ctl_q.state == ST_SHIFT);
        scan_en    = (ctl_q.state == ST_SHIFT) || (ctl_q.state == ST_FLUSH);
        sff_en     = scan_en || (ctl_q.state == ST_CAP);
        capture    = (ctl_q.state == ST_CAP) || merged;
        nsff_en    = capture;
        so_valid   = scan_en;
        done       = (ctl_q.state == ST_DONE);
    end
endmodule

// File: rtl/sss_shreg.sv
module sss_shreg #(
    parameter int CHAIN_LEN = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [CHAIN_LEN-1:0] load_data,
    input  logic                 advance,
    output logic                 head
);
    typedef struct packed {
        logic [CHAIN_LEN-1:0] bits;
    } shreg_t;

    shreg_t sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (load)         sr_d.bits = load_data;
        else if (advance) sr_d.bits = {1'b0, sr_q.bits[CHAIN_LEN-1:1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign head = sr_q.bits[0];
endmodule

// File: rtl/sss_cyccnt.sv
module sss_cyccnt #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic [CNT_W-1:0] val;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc) cnt_d.val = cnt_q.val + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q.val;
endmodule

// File: rtl/sel_scan_seq.sv
module sel_scan_seq #(
    parameter int CHAIN_LEN = 8,
    parameter int CNT_W     = 32,
    parameter int SHW       = $clog2(CHAIN_LEN + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 desc_valid,
    output logic                 desc_ready,
    input  logic [SHW-1:0]       desc_shifts,
    input  logic [CHAIN_LEN-1:0] desc_data,
    input  logic                 desc_concur,
    input  logic                 desc_last,
    input  logic                 desc_scanless,
    output logic                 scan_en,
    output logic                 sff_en,
    output logic                 nsff_en,
    output logic                 scan_in,
    output logic                 capture,
    output logic                 so_valid,
    output logic                 done,
    output logic [CNT_W-1:0]     cycle_count
);
    logic accept, advance, data_sel, head;

    sss_ctrl #(.CHAIN_LEN(CHAIN_LEN), .SHW(SHW)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .desc_valid    (desc_valid),
        .desc_shifts   (desc_shifts),
        .desc_concur   (desc_concur),
        .desc_last     (desc_last),
        .desc_scanless (desc_scanless),
        .desc_ready    (desc_ready),
        .accept        (accept),
        .advance       (advance),
        .scan_en       (scan_en),
        .sff_en        (sff_en),
        .nsff_en       (nsff_en),
        .capture       (capture),
        .so_valid      (so_valid),
        .data_sel      (data_sel),
        .done          (done)
    );

    sss_shreg #(.CHAIN_LEN(CHAIN_LEN)) u_shreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_data (desc_data),
        .advance   (advance),
        .head      (head)
    );

    sss_cyccnt #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (sff_en || nsff_en),
        .count (cycle_count)
    );

    assign scan_in = data_sel && head;
endmodule

// File: rtl/sss_chk.sv
module sss_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             desc_ready,
    input logic             scan_en,
    input logic             sff_en,
    input logic             nsff_en,
    input logic             capture,
    input logic             so_valid,
    input logic             done,
    input logic [CNT_W-1:0] cycle_count
);
    // R2
    shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en && !capture) |-> (sff_en && !nsff_en && so_valid));

    // R4
    capture_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && !scan_en) |-> (sff_en && nsff_en && !so_valid));

    // R5
    merged_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && scan_en) |-> (sff_en && nsff_en && so_valid));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        desc_ready |-> (!sff_en && !nsff_en && !scan_en));

    // R8
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done && !desc_ready));

    // R9
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sff_en || nsff_en) |=> (cycle_count == $past(cycle_count) + CNT_W'(1)));

    // R9
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sff_en || nsff_en) |=> $stable(cycle_count));
endmodule

bind sel_scan_seq sss_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .desc_ready  (desc_ready),
    .scan_en     (scan_en),
    .sff_en      (sff_en),
    .nsff_en     (nsff_en),
    .capture     (capture),
    .so_valid    (so_valid),
    .done        (done),
    .cycle_count (cycle_count)
);

// File: tb/sel_scan_seq_tb.sv
module sel_scan_seq_tb;
    localparam int S     = 8;
    localparam int CNT_W = 32;
    localparam int SHW   = $clog2(S + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             desc_valid = 1'b0;
    logic             desc_ready;
    logic [SHW-1:0]   desc_shifts = '0;
    logic [S-1:0]     desc_data = '0;
    logic             desc_concur = 1'b0;
    logic             desc_last = 1'b0;
    logic             desc_scanless = 1'b0;
    logic             scan_en, sff_en, nsff_en, scan_in, capture, so_valid, done;
    logic [CNT_W-1:0] cycle_count;

    int checks = 0;
    int errors = 0;
    int exp_total = 0;

    always #5 clk = ~clk;

    sel_scan_seq #(.CHAIN_LEN(S), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_ready(desc_ready),
        .desc_shifts(desc_shifts), .desc_data(desc_data), .desc_concur(desc_concur),
        .desc_last(desc_last), .desc_scanless(desc_scanless), .scan_en(scan_en),
        .sff_en(sff_en), .nsff_en(nsff_en), .scan_in(scan_in), .capture(capture),
        .so_valid(so_valid), .done(done), .cycle_count(cycle_count)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_desc(input int n, input logic [S-1:0] data, input bit conc,
                            input bit last, input bit sless);
        int eff, n_so, n_cap, n_merge, n_act, bad_bit, bad_hold, n_gap;
        int exp_so, exp_act;
        eff = (n > S) ? S : n;
        if (sless) eff = 0;
        n_so = 0; n_cap = 0; n_merge = 0; n_act = 0; bad_bit = 0; bad_hold = 0; n_gap = 0;
        desc_shifts   = SHW'(n);
        desc_data     = data;
        desc_concur   = conc;
        desc_last     = last;
        desc_scanless = sless;
        desc_valid    = 1'b1;
        @(posedge clk);
        #1 desc_valid = 1'b0;
        for (int c = 0; c < 64; c++) begin
            @(negedge clk);
            if (desc_ready || done) break;
            if (sff_en || nsff_en) n_act++;
            else n_gap++;
            if (capture) n_cap++;
            if (capture && scan_en) n_merge++;
            if (scan_en && !capture && nsff_en) bad_hold++;
            if (so_valid) begin
                if (scan_in !== ((n_so < eff) ? data[n_so] : 1'b0)) bad_bit++;
                n_so++;
            end
        end
        exp_so  = eff + (last ? S : 0);
        exp_act = ((eff == 0) ? 1 : eff + (conc ? 0 : 1)) + (last ? S : 0);
        exp_total += exp_act;
        chk(n_so == exp_so, "R3 shift cycle count", n_so, exp_so);
        chk(bad_bit == 0, "R2 scan_in bit order", bad_bit, 0);
        chk(bad_hold == 0, "R2 non-scanned held while shifting", bad_hold, 0);
        chk(n_cap == 1, "R4 one capture per pattern", n_cap, 1);
        chk(n_act == exp_act, sless ? "R6 scanless cycles" : "R5 pattern cycles", n_act, exp_act);
        chk(n_merge == ((conc && eff > 0) ? 1 : 0), "R5 merged capture",
            n_merge, (conc && eff > 0) ? 1 : 0);
        chk(n_gap == 0, "R7 no idle cycle inside pattern", n_gap, 0);
        if (!last) begin
            chk(desc_ready && !scan_en && !sff_en && !nsff_en, "R7 hold while waiting",
                {desc_ready, scan_en, sff_en, nsff_en}, 4'b1000);
        end
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(desc_ready && !done && cycle_count == 0 && !scan_en && !sff_en && !nsff_en &&
            !capture && !so_valid, "R1 reset state", int'(cycle_count), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(desc_ready && cycle_count == 0, "R1 idle after reset", int'(cycle_count), 0);
        for (int cc = 0; cc < 2; cc++) begin
            for (int n = 0; n <= 10; n++) begin
                run_desc(n, S'(8'hA5 ^ (n * 37) ^ (cc * 90)), bit'(cc), 1'b0, 1'b0);
            end
        end
        run_desc(5, S'(8'h3C), 1'b0, 1'b0, 1'b1);
        run_desc(5, S'(8'hC3), 1'b1, 1'b0, 1'b1);
        run_desc(15, S'(8'hFF), 1'b1, 1'b0, 1'b0);
        chk(int'(cycle_count) == exp_total, "R9 running count", int'(cycle_count), exp_total);
        run_desc(3, S'(8'h06), 1'b0, 1'b1, 1'b0);
        chk(done && !desc_ready, "R8 done after flush", {done, desc_ready}, 2'b10);
        chk(int'(cycle_count) == exp_total, "R9 final count", int'(cycle_count), exp_total);
        desc_shifts = SHW'(4);
        desc_valid  = 1'b1;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk(done && !desc_ready && !scan_en && !sff_en && !nsff_en && !capture &&
                int'(cycle_count) == exp_total, "R8 ignored after done",
                int'(cycle_count), exp_total);
        end
        desc_valid = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule